// File: doc/BRIEF.md
# Single-Channel DMA Engine with Burst and Cycle-Steal Modes

The engine copies a block of bytes from a slow byte-wide peripheral into memory over a system bus that a CPU normally owns. Software supplies a start address, a byte count and a mode, then pulses `start`. The engine asks the CPU for the bus with a request/grant handshake, writes the bytes to consecutive addresses, hands the bus back, and pulses `done`.

There are two modes. In burst mode the bus is requested once and kept for the whole block. Each byte is written in the cycle after the peripheral strobes it, so the device's pace sets how long the bus is held. In cycle-steal mode each byte is first latched into a one-byte holding register. Only then is the bus requested. The byte is written in a single bus cycle and the bus is released straight away, so the bus is held once per byte for only the grant latency, one transfer cycle and the release latency.

Top module: `dma_xfer_engine`

## Requirements
- R1: After a synchronous active-low reset, `bus_req`, `mem_we` and `done` are 0 and `mem_addr` is 0.
- R2: `bus_req` stays high from the cycle it rises until `bus_gnt` is seen. `mem_we` is high only while `bus_gnt` is high. While `bus_gnt` is low, `mem_addr`, `mem_wdata` and `mem_we` are all 0.
- R3: In burst mode (`mode_i`=0), `bus_req` rises exactly once per block. It stays high until the last byte is written, so every byte of the block is written inside a single grant window.
- R4: In burst mode, once the bus is granted, a byte strobed on `dev_valid` in cycle c is written to memory (`mem_we`=1) in cycle c+1.
- R5: In cycle-steal mode (`mode_i`=1), the request for a byte rises only after that byte has been latched. A byte strobed in cycle c raises `bus_req` in cycle c+2.
- R6: In cycle-steal mode, each byte gets its own request. Every grant window contains exactly one write, and `bus_req` is low in the cycle after each write.
- R7: Byte k of a block (k from 0) is written to address `cfg_base + k` modulo 2^AW, with the data in the order the peripheral delivered it.
- R8: After the last byte, `done` pulses for exactly one cycle, and only when `bus_req` and `bus_gnt` are both low.
- R9: A start with `cfg_len`=0 pulses `done` without ever raising `bus_req` and without writing.
- R10: A `start` seen while a transfer is in progress is ignored. The running block keeps its address, count and mode.
- R11: `mode_i` and the configuration inputs are sampled only at an accepted start. Changing them mid-block does not change the behaviour of that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a block when the engine is idle |
| mode_i | input | 1 | 0 = burst, 1 = cycle-steal; sampled at start |
| cfg_base | input | AW | First memory address of the block |
| cfg_len | input | CW | Number of bytes in the block |
| bus_req | output | 1 | Request for the system bus |
| bus_gnt | input | 1 | Grant of the system bus from the CPU |
| dev_data | input | 8 | Peripheral byte |
| dev_valid | input | 1 | One-cycle strobe marking `dev_data` valid |
| mem_addr | output | AW | Memory write address, 0 when not granted |
| mem_wdata | output | 8 | Memory write data, 0 when not granted |
| mem_we | output | 1 | Memory write enable |
| done | output | 1 | One-cycle pulse at the end of a block |

## Verification
The hardest situation to reach is a `start` pulse, with a changed mode and a changed address, landing in the middle of a live cycle-steal block. Most of that block is spent between grant windows, waiting on the slow device. The bench drives a stray `start` with a new base and a flipped `mode_i` partway through a steal block, while the bus is released. It then confirms that every address still follows the original base and that one request per byte still occurs. The sweep covers both modes, several lengths including zero, and a base next to the top of the address space, so that the address wraps.

// File: rtl/dma_pkg.sv
// Shared types for the DMA engine: transfer mode and controller state.
package dma_pkg;
    typedef enum logic {
        XM_BURST = 1'b0,
        XM_STEAL = 1'b1
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_REQ,
        ST_XFER,
        ST_REL,
        ST_DONE
    } eng_state_e;
endpackage

// File: rtl/dma_hold_buf.sv
// One-entry holding register between the peripheral and the memory port.
// Assumes the peripheral strobes no faster than bytes are consumed; a push
// into a full entry is accepted only when the same cycle pops it.
module dma_hold_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] dout
);
    // Capture a strobed byte, clear on consumption, flush when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (!enable) begin
            full <= 1'b0;
        end else if (push && (!full || pop)) begin
            full <= 1'b1;
            dout <= din;
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    p_pop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> full);
endmodule

// File: rtl/dma_addr_cnt.sv
// Address pointer and remaining-byte counter. Loaded at start, stepped once
// per byte written. The address wraps modulo 2^AW.
module dma_addr_cnt #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] len,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last,
    output logic          empty
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] remaining;

    // Load the block parameters or advance by one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr      <= '0;
            remaining <= '0;
        end else if (load) begin
            addr      <= base;
            remaining <= len;
        end else if (step) begin
            addr      <= addr + AW'(1);
            remaining <= remaining - ONE;
        end
    end

    // Flags for the controller.
    always_comb begin
        last  = (remaining == ONE);
        empty = (remaining == '0);
    end

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr == $past(addr) + AW'(1)));
endmodule

// File: rtl/dma_ctrl_fsm.sv
// Sequencer for the bus handshake. Burst: request once, write each byte as it
// arrives, release after the last. Cycle-steal: wait for a held byte, request,
// write once, release, repeat. Assumes the CPU keeps grant high while the
// request is high, and drops grant some time after the request falls.
module dma_ctrl_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_i,
    input  logic len_zero,
    input  logic hold_full,
    input  logic bus_gnt,
    input  logic last,
    input  logic empty,
    output logic bus_req,
    output logic load,
    output logic write,
    output logic buf_en,
    output logic owning,
    output logic done
);
    eng_state_e state, nxt;
    xfer_mode_e mode_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Latch the mode only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mode_q <= XM_BURST;
        else if (state == ST_IDLE && start) mode_q <= xfer_mode_e'(mode_i);
    end

    // Next state, load strobe and write strobe.
    always_comb begin
        nxt   = state;
        load  = 1'b0;
        write = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (len_zero)                        nxt = ST_DONE;
                    else if (xfer_mode_e'(mode_i) == XM_STEAL) nxt = ST_COLLECT;
                    else                                 nxt = ST_REQ;
                end
            end
            ST_COLLECT: if (hold_full) nxt = ST_REQ;
            ST_REQ:     if (bus_gnt)   nxt = ST_XFER;
            ST_XFER: begin
                write = hold_full && bus_gnt;
                if (write && (mode_q == XM_STEAL || last)) nxt = ST_REL;
            end
            ST_REL:  if (!bus_gnt) nxt = empty ? ST_DONE : ST_COLLECT;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Moore outputs.
    always_comb begin
        bus_req = (state == ST_REQ) || (state == ST_XFER);
        owning  = (state == ST_XFER);
        buf_en  = (state != ST_IDLE) && (state != ST_DONE);
        done    = (state == ST_DONE);
    end

    p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_BURST && bus_req && !(write && last)) |=> bus_req);
    p_steal_after_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_STEAL && $rose(bus_req)) |-> hold_full);
    p_steal_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_STEAL && write) |=> !bus_req);
    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_gnt && !bus_req));
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(mode_q));
endmodule

// File: rtl/dma_xfer_engine.sv
// Top of the single-channel DMA engine. Wires the holding register, the
// address/count unit and the sequencer. Memory-side outputs are forced to
// zero whenever the engine does not own a granted bus.
module dma_xfer_engine #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_i,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_len,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic [7:0]    dev_data,
    input  logic          dev_valid,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic          done
);
    logic          hold_full, load, write, buf_en, owning, last, empty;
    logic [7:0]    hold_q;
    logic [AW-1:0] cur_addr;

    dma_hold_buf #(.DW(8)) u_hold (
        .clk(clk), .rst_n(rst_n), .enable(buf_en), .push(dev_valid),
        .din(dev_data), .pop(write), .full(hold_full), .dout(hold_q)
    );

    dma_addr_cnt #(.AW(AW), .CW(CW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .base(cfg_base), .len(cfg_len),
        .step(write), .addr(cur_addr), .last(last), .empty(empty)
    );

    dma_ctrl_fsm u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode_i),
        .len_zero(cfg_len == '0), .hold_full(hold_full), .bus_gnt(bus_gnt),
        .last(last), .empty(empty), .bus_req(bus_req), .load(load),
        .write(write), .buf_en(buf_en), .owning(owning), .done(done)
    );

    // Drive the memory port only while the granted bus is ours.
    always_comb begin
        mem_we    = write;
        mem_addr  = (owning && bus_gnt) ? cur_addr : '0;
        mem_wdata = (owning && bus_gnt) ? hold_q   : '0;
    end

    p_we_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> bus_gnt);
    p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);
    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_gnt |-> (mem_addr == '0 && mem_wdata == '0 && !mem_we));
endmodule

// File: tb/dma_xfer_engine_tb.sv
// Sweep bench: both modes, several lengths, two base addresses, plus a
// disturbed run. Models a CPU with fixed grant and release latencies and a
// slow peripheral.
module dma_xfer_engine_tb;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int GLAT = 5;
    localparam int RLAT = 5;
    localparam int DGAP = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode_i = 1'b0, bus_gnt = 1'b0, dev_valid = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_len = '0;
    logic [7:0] dev_data = '0;
    logic bus_req, mem_we, done;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0, fails = 0;
    int cyc = 0;
    int wr_n, rise_n, stb_n, done_n, done_bad, float_err, max_win, win_cnt;
    int wr_addr [64];
    int wr_data [64];
    int wr_cyc  [64];
    int stb_cyc [64];
    int rise_cyc[64];
    logic prev_req = 1'b0, prev_gnt = 1'b0;
    int gcnt = 0;

    always #2.5 clk = ~clk;

    dma_xfer_engine #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode_i),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .dev_data(dev_data), .dev_valid(dev_valid),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int base, input int k, input int m);
        return 8'(base ^ (k * 37) ^ (m * 91));
    endfunction

    // CPU model: grant after GLAT cycles of request, release after RLAT.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt = 1'b0; gcnt = 0;
        end else if (bus_req != bus_gnt) begin
            gcnt++;
            if (gcnt >= (bus_req ? GLAT : RLAT)) begin
                bus_gnt = bus_req; gcnt = 0;
            end
        end else begin
            gcnt = 0;
        end
    end

    // Monitor: samples just after the falling edge.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            cyc++;
            if (dev_valid && stb_n < 64) begin stb_cyc[stb_n] = cyc; stb_n++; end
            if (mem_we && wr_n < 64) begin
                wr_addr[wr_n] = int'(mem_addr); wr_data[wr_n] = int'(mem_wdata);
                wr_cyc[wr_n] = cyc; wr_n++;
            end
            if (bus_req && !prev_req && rise_n < 64) begin rise_cyc[rise_n] = cyc; rise_n++; end
            if (bus_gnt && mem_we) win_cnt++;
            if (prev_gnt && !bus_gnt) begin
                if (win_cnt > max_win) max_win = win_cnt;
                win_cnt = 0;
            end
            if (!bus_gnt && (mem_we || mem_addr != '0 || mem_wdata != '0)) float_err++;
            if (done) begin
                done_n++;
                if (bus_gnt || bus_req) done_bad++;
            end
            prev_req = bus_req; prev_gnt = bus_gnt;
        end
    end

    task automatic run_xfer(input int m, input int base, input int len, input bit disturb);
        int wait_c;
        wr_n = 0; rise_n = 0; stb_n = 0; done_n = 0; done_bad = 0;
        float_err = 0; max_win = 0; win_cnt = 0;
        @(negedge clk);
        mode_i = m[0]; cfg_base = AW'(base); cfg_len = CW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                for (int k = 0; k < len; k++) begin
                    repeat (DGAP) @(negedge clk);
                    dev_data = pat(base, k, m); dev_valid = 1'b1;
                    @(negedge clk);
                    dev_valid = 1'b0;
                end
            end
            begin
                if (disturb) begin
                    repeat (DGAP + 20) @(negedge clk);
                    mode_i = ~m[0]; cfg_base = AW'(base + 16'h0100); start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        wait_c = 0;
        while (done_n == 0 && wait_c < 2000) begin @(negedge clk); wait_c++; end
        repeat (4) @(negedge clk);
        chk(wait_c < 2000, "R8 timeout", wait_c, 0);
        chk(done_n == 1, "R8 done pulses", done_n, 1);
        chk(done_bad == 0, "R8 done with bus held", done_bad, 0);
        chk(float_err == 0, "R2 bus driven without grant", float_err, 0);
        chk(wr_n == len, "R7 write count", wr_n, len);
        if (len == 0) chk(rise_n == 0, "R9 request on empty block", rise_n, 0);
        for (int k = 0; k < len && k < wr_n; k++) begin
            chk(wr_addr[k] == ((base + k) & 16'hFFFF), "R7 address",
                wr_addr[k], (base + k) & 16'hFFFF);
            chk(wr_data[k] == int'(pat(base, k, m)), "R7 data",
                wr_data[k], int'(pat(base, k, m)));
            if (m == 0 && k < stb_n)
                chk(wr_cyc[k] - stb_cyc[k] == 1, "R4 write pacing", wr_cyc[k] - stb_cyc[k], 1);
            if (m == 1 && k < stb_n && k < rise_n)
                chk(rise_cyc[k] - stb_cyc[k] == 2, "R5 request after capture",
                    rise_cyc[k] - stb_cyc[k], 2);
        end
        if (len > 0) begin
            if (m == 0) begin
                chk(rise_n == 1, "R3 single request", rise_n, 1);
                chk(max_win == len, "R3 writes in one window", max_win, len);
            end else begin
                chk(rise_n == len, disturb ? "R11 one request per byte" : "R6 one request per byte",
                    rise_n, len);
                chk(max_win == 1, "R6 one write per window", max_win, 1);
            end
        end
        if (disturb) chk(wr_n > 0 && wr_addr[0] == base, "R10 base kept", wr_n > 0 ? wr_addr[0] : -1, base);
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lens[6];
        int bases[2];
        lens = '{0, 1, 2, 3, 7, 16};
        bases = '{16'h0010, 16'hFFFE};
        repeat (3) @(negedge clk);
        #1;
        chk(bus_req == 1'b0, "R1 bus_req at reset", int'(bus_req), 0);
        chk(mem_we == 1'b0, "R1 mem_we at reset", int'(mem_we), 0);
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(mem_addr == '0, "R1 mem_addr at reset", int'(mem_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++)
            for (int b = 0; b < 2; b++)
                for (int l = 0; l < 6; l++)
                    run_xfer(m, bases[b], lens[l], 1'b0);
        run_xfer(1, 16'h0200, 4, 1'b1);
        run_xfer(0, 16'h0300, 4, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule